// File: doc/BRIEF.md
# Barrel shifter with carry-out

This block is a purely combinational 32-bit shifter for the operand path of a processor datapath. It performs four shift kinds: logical left, logical right, arithmetic right and rotate right. Alongside the shifted value it produces a shifter carry, which the surrounding flag logic can take as the new C flag.

The shift amount comes from one of two sources. The first is a 5-bit immediate field. The second is the whole low byte of a count register. A register amount can therefore reach 255, and a set of boundary rules covers zero, exactly 32, above 32, and, for rotate, nonzero multiples of 32. When the flag-update enable is low, the carry output simply follows the incoming C flag.

The block holds no state and has no clock. It presents no valid/ready handshake. A caller drives the operand and the controls, and reads the result and the carry in the same cycle. There is no back-pressure to manage.

Top module: `bshift_carry`

## Requirements
- R1: `amt_sel_i`=0 takes the amount from the 5-bit `imm_amt_i`, and `reg_amt_i` then has no effect. `amt_sel_i`=1 takes all 8 bits of `reg_amt_i` as the amount (0 to 255).
- R2: An amount of zero, from either source and for every shift kind, returns the operand unchanged and sets `carry_o` equal to `carry_i`.
- R3: Logical left (`kind_i`=2'b00) by n in 1..31 gives operand<<n, and its carry is operand bit (32-n).
- R4: Logical right (`kind_i`=2'b01) and arithmetic right (`kind_i`=2'b10) by n in 1..31 give the shifted value, zero-filled or sign-filled as the kind requires. Their carry is operand bit (n-1).
- R5: A logical shift by exactly 32 returns zero. The carry is operand bit 0 for a left shift and operand bit 31 for a right shift.
- R6: A logical shift by 33 to 255 returns zero with a carry of 0.
- R7: An arithmetic right shift by 32 to 255 returns 32 copies of operand bit 31, and its carry is operand bit 31.
- R8: Rotate right (`kind_i`=2'b11) uses the amount modulo 32. For a nonzero residue r, it rotates by r and its carry is operand bit (r-1).
- R9: Rotate right by a nonzero amount whose low five bits are zero returns the operand unchanged, and its carry is operand bit 31.
- R10: With `flag_en_i`=0, `carry_o` equals `carry_i` for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to shift |
| kind_i | input | 2 | Shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_sel_i | input | 1 | Amount source: 0 immediate, 1 count-register low byte |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 8 | Low byte of the count register |
| carry_i | input | 1 | Current C flag |
| flag_en_i | input | 1 | Allow the shifter to produce a new carry |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Next C flag |

## Verification
The hardest cases to reach are the register amounts that differ from the immediate form. These are exactly 32, 33 to 255, and the nonzero multiples of 32 for rotate. Each has its own result and carry rule, and a short or random amount range rarely hits them. The bench therefore sweeps every register byte value from 0 to 255, and every immediate value, for all four kinds. It repeats the sweep over operands with distinct end bits, both carry-in values and both flag-enable settings. During the immediate sweep it drives the register byte with changing values, which shows that the unused source has no effect.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/bshift_amount.sv
module bshift_amount
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 5,
  parameter int LIN_W  = 6,
  parameter int ROT_W  = 5
) (
  input  logic [1:0]       kind_i,
  input  logic             amt_sel_i,
  input  logic [IMM_W-1:0] imm_amt_i,
  input  logic [CNT_W-1:0] reg_amt_i,
  output logic [CNT_W-1:0] amt_o,
  output logic             zero_o,
  output logic [LIN_W-1:0] lin_amt_o,
  output logic [ROT_W-1:0] rot_amt_o
);
  // The linear network saturates at DATA_W+1 for logical kinds, which pushes
  // every operand bit and the guard bit out. Arithmetic saturates at DATA_W.
  localparam int LOG_CAP = DATA_W + 1;
  localparam int ARI_CAP = DATA_W;

  logic [CNT_W-1:0] cap;

  always_comb begin
    amt_o = amt_sel_i ? reg_amt_i
                      : {{(CNT_W-IMM_W){1'b0}}, imm_amt_i};
    zero_o    = (amt_o == '0);
    rot_amt_o = amt_o[ROT_W-1:0];
    cap = (shift_kind_e'(kind_i) == SK_ASR) ? CNT_W'(ARI_CAP) : CNT_W'(LOG_CAP);
    if (amt_o > cap) lin_amt_o = LIN_W'(cap);
    else             lin_amt_o = LIN_W'(amt_o);
  end

  always_comb begin
    if (!amt_sel_i)
      AST_IMM_SOURCE: assert (amt_o[CNT_W-1:IMM_W] == '0); // R1
  end
endmodule

// File: rtl/bshift_net.sv
module bshift_net #(
  parameter int W      = 33,
  parameter int STG    = 6,
  parameter bit ROTATE = 1'b0
) (
  input  logic [W-1:0]   data_i,
  input  logic           fill_i,
  input  logic [STG-1:0] amt_i,
  output logic [W-1:0]   data_o
);
  logic [W-1:0] lvl [STG+1];

  assign lvl[0] = data_i;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [W-1:0] moved;
    if (SH >= W) begin : g_flush
      assign moved = ROTATE ? lvl[k] : {W{fill_i}};
    end else if (ROTATE) begin : g_rot
      assign moved = {lvl[k][SH-1:0], lvl[k][W-1:SH]};
    end else begin : g_lin
      assign moved = {{SH{fill_i}}, lvl[k][W-1:SH]};
    end
    assign lvl[k+1] = amt_i[k] ? moved : lvl[k];
  end

  assign data_o = lvl[STG];
endmodule

// File: rtl/bshift_outsel.sv
module bshift_outsel
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        kind_i,
  input  logic              zero_i,
  input  logic              flag_en_i,
  input  logic              carry_i,
  input  logic [DATA_W:0]   lin_i,
  input  logic [DATA_W-1:0] rot_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] lin_val;
  logic [DATA_W-1:0] lin_rev;

  assign lin_val = lin_i[DATA_W:1];

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign lin_rev[b] = lin_val[DATA_W-1-b];
  end

  always_comb begin
    unique case (shift_kind_e'(kind_i))
      SK_LSL:  result_o = lin_rev;
      SK_ROR:  result_o = rot_i;
      default: result_o = lin_val;
    endcase
    if (!flag_en_i || zero_i)                 carry_o = carry_i;
    else if (shift_kind_e'(kind_i) == SK_ROR) carry_o = rot_i[DATA_W-1];
    else                                      carry_o = lin_i[0];
  end
endmodule

// File: rtl/bshift_carry.sv
module bshift_carry
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        kind_i,
  input  logic              amt_sel_i,
  input  logic [IMM_W-1:0]  imm_amt_i,
  input  logic [CNT_W-1:0]  reg_amt_i,
  input  logic              carry_i,
  input  logic              flag_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int ROT_W = $clog2(DATA_W);
  localparam int LIN_W = $clog2(DATA_W + 2);
  localparam int LIN_D = DATA_W + 1;

  logic [CNT_W-1:0]  amt;
  logic              amt_zero;
  logic [LIN_W-1:0]  lin_amt;
  logic [ROT_W-1:0]  rot_amt;
  logic [DATA_W-1:0] opnd_rev;
  logic [DATA_W-1:0] lin_src;
  logic              lin_fill;
  logic [LIN_D-1:0]  lin_out;
  logic [DATA_W-1:0] rot_out;

  bshift_amount #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W), .LIN_W(LIN_W), .ROT_W(ROT_W)
  ) amount_i (
    .kind_i   (kind_i),
    .amt_sel_i(amt_sel_i),
    .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i),
    .amt_o    (amt),
    .zero_o   (amt_zero),
    .lin_amt_o(lin_amt),
    .rot_amt_o(rot_amt)
  );

  // Left shifts reuse the right-shifting network on the bit-reversed operand.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign opnd_rev[b] = opnd_i[DATA_W-1-b];
  end

  assign lin_src  = (shift_kind_e'(kind_i) == SK_LSL) ? opnd_rev : opnd_i;
  assign lin_fill = (shift_kind_e'(kind_i) == SK_ASR) ? opnd_i[DATA_W-1] : 1'b0;

  // A guard bit below the operand catches the last bit shifted out.
  bshift_net #(.W(LIN_D), .STG(LIN_W), .ROTATE(1'b0)) lin_net_i (
    .data_i({lin_src, 1'b0}),
    .fill_i(lin_fill),
    .amt_i (lin_amt),
    .data_o(lin_out)
  );

  bshift_net #(.W(DATA_W), .STG(ROT_W), .ROTATE(1'b1)) rot_net_i (
    .data_i(opnd_i),
    .fill_i(1'b0),
    .amt_i (rot_amt),
    .data_o(rot_out)
  );

  bshift_outsel #(.DATA_W(DATA_W)) outsel_i (
    .kind_i   (kind_i),
    .zero_i   (amt_zero),
    .flag_en_i(flag_en_i),
    .carry_i  (carry_i),
    .lin_i    (lin_out),
    .rot_i    (rot_out),
    .result_o (result_o),
    .carry_o  (carry_o)
  );

  always_comb begin
    if (amt_zero)
      AST_ZERO_PASS: assert (result_o == opnd_i && carry_o == carry_i); // R2
    if (!flag_en_i)
      AST_FLAG_HOLD: assert (carry_o == carry_i); // R10
    if ((shift_kind_e'(kind_i) == SK_LSL || shift_kind_e'(kind_i) == SK_LSR)
        && amt >= CNT_W'(DATA_W))
      AST_LOGIC_WIPE: assert (result_o == '0); // R5
    if ((shift_kind_e'(kind_i) == SK_LSL || shift_kind_e'(kind_i) == SK_LSR)
        && amt > CNT_W'(DATA_W) && flag_en_i)
      AST_FAR_CARRY: assert (!carry_o); // R6
    if (shift_kind_e'(kind_i) == SK_ASR && amt >= CNT_W'(DATA_W))
      AST_SIGN_FILL: assert (result_o == {DATA_W{opnd_i[DATA_W-1]}}); // R7
    if (shift_kind_e'(kind_i) == SK_ROR && !amt_zero && rot_amt == '0)
      AST_ROT_WRAP: assert (result_o == opnd_i
                            && (!flag_en_i || carry_o == opnd_i[DATA_W-1])); // R9
  end
endmodule

// File: tb/bshift_carry_tb_top.sv
module bshift_carry_tb_top;
  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [1:0]  kind;
  logic        amt_sel;
  logic [4:0]  imm_amt;
  logic [7:0]  reg_amt;
  logic        cin;
  logic        fen;
  logic [31:0] result;
  logic        cout;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bshift_carry dut_i (
    .opnd_i(opnd), .kind_i(kind), .amt_sel_i(amt_sel), .imm_amt_i(imm_amt),
    .reg_amt_i(reg_amt), .carry_i(cin), .flag_en_i(fen),
    .result_o(result), .carry_o(cout)
  );

  function automatic logic [32:0] model(logic [31:0] op, logic [1:0] k, int n,
                                        logic ci, logic fe);
    logic [31:0] r;
    logic        c;
    int          m;
    r = op; c = ci;
    if (n != 0) begin
      case (k)
        2'b00: if (n < 32) begin r = op << n; c = op[32-n]; end
               else if (n == 32) begin r = '0; c = op[0]; end
               else begin r = '0; c = 1'b0; end
        2'b01: if (n < 32) begin r = op >> n; c = op[n-1]; end
               else if (n == 32) begin r = '0; c = op[31]; end
               else begin r = '0; c = 1'b0; end
        2'b10: if (n < 32) begin r = 32'($signed(op) >>> n); c = op[n-1]; end
               else begin r = {32{op[31]}}; c = op[31]; end
        default: begin
          m = n % 32;
          if (m == 0) begin r = op; c = op[31]; end
          else begin r = (op >> m) | (op << (32 - m)); c = op[m-1]; end
        end
      endcase
    end
    if (!fe) c = ci;
    return {c, r};
  endfunction

  function automatic string tag_of(logic [1:0] k, int n);
    if (n == 0) return "R2";
    if (k == 2'b11) return (n % 32 == 0) ? "R9" : "R8";
    if (n < 32) return (k == 2'b00) ? "R3" : "R4";
    if (k == 2'b10) return "R7";
    return (n == 32) ? "R5" : "R6";
  endfunction

  task automatic check_vec(string rtag, string ctag, logic [32:0] exp);
    n_run++;
    if (result !== exp[31:0]) begin
      n_fail++;
      $display("FAIL %s result: actual %h expected %h (kind %0d sel %0d imm %0d reg %0d op %h)",
               rtag, result, exp[31:0], kind, amt_sel, imm_amt, reg_amt, opnd);
    end
    n_run++;
    if (cout !== exp[32]) begin
      n_fail++;
      $display("FAIL %s carry: actual %0b expected %0b (kind %0d sel %0d imm %0d reg %0d op %h cin %0b fen %0b)",
               ctag, cout, exp[32], kind, amt_sel, imm_amt, reg_amt, opnd, cin, fen);
    end
  endtask

  initial begin
    logic [31:0] ops [4];
    ops[0] = 32'h8000_0001;
    ops[1] = 32'h7FFF_FFFE;
    ops[2] = 32'hC35A_96F0;
    ops[3] = 32'h0F0F_1E2D;

    opnd = '0; kind = '0; amt_sel = 1'b0; imm_amt = '0; reg_amt = '0;
    cin = 1'b0; fen = 1'b1;
    @(negedge clk); #1;
    check_vec("R2", "R2", 33'h0);  // idle inputs: zero out, carry follows

    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 4; o++)
        for (int c = 0; c < 2; c++)
          for (int f = 0; f < 2; f++) begin
            // register byte source, every value 0..255
            for (int n = 0; n < 256; n++) begin
              @(negedge clk);
              opnd = ops[o]; kind = 2'(k); cin = c[0]; fen = f[0];
              amt_sel = 1'b1; reg_amt = 8'(n); imm_amt = 5'(~n);
              #1;
              check_vec(n == 32 || n > 32 ? tag_of(2'(k), n) : "R1",
                        f == 0 ? "R10" : tag_of(2'(k), n),
                        model(ops[o], 2'(k), n, c[0], f[0]));
            end
            // immediate source with a changing, ignored register byte
            for (int n = 0; n < 32; n++) begin
              @(negedge clk);
              opnd = ops[o]; kind = 2'(k); cin = c[0]; fen = f[0];
              amt_sel = 1'b0; imm_amt = 5'(n); reg_amt = 8'(8'hE0 + n * 7);
              #1;
              check_vec("R1", f == 0 ? "R10" : tag_of(2'(k), n),
                        model(ops[o], 2'(k), n, c[0], f[0]));
            end
          end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule